// File: doc/BRIEF.md
# Register-Access SPI Command Master

This block drives an SPI link to an audio codec peripheral and turns single requests into complete bus transactions. A request carries a kind (register read, register write, register write without the ready check, or one raw stream byte), an 8-bit register address and 16 bits of write data. For register traffic it lowers a dedicated control chip select and clocks out a fixed four-byte frame. The frame is an opcode, the address, then either two data bytes or two filler bytes. On a read, the reply is assembled from the last two bytes on the return line. Stream bytes travel under a second chip select, one byte per request.

Both chip selects are framed by a programmable guard interval. Ordinary register writes are held back until the peripheral's ready line is high. The no-wait write and reads skip that check. A `busy` output covers each request from acceptance to chip-select release, and a single-cycle `done` pulse marks completion. The SPI clock runs at a fixed division of the system clock, set by a parameter.

Top module: `regspi_master`

## Requirements
- R1: A request with `req_kind` = 2'b01 (register write) sends the bytes 0x02, `req_addr`, `req_wdata[15:8]`, `req_wdata[7:0]` in that order, each most significant bit first.
- R2: A request with `req_kind` = 2'b00 (register read) sends 0x03, `req_addr`, 0xFF, 0xFF. The third byte returned on `miso` becomes `rdata[15:8]` and the fourth becomes `rdata[7:0]`. `rdata` changes only in the cycle `done` is high, and only on reads.
- R3: `ctl_csn` stays low without a break from before the first byte of a register request until after its last byte. It is never low at the same time as `dat_csn`.
- R4: With guard value G (`guard_len`, sampled at acceptance), the first rising `sclk` comes G+H+1 cycles after chip select falls, and chip select rises G+2 cycles after the final falling `sclk`. H is the half-period parameter.
- R5: A register write (2'b01) accepted while `ready_in` is low keeps both chip selects high and `busy` high. Its chip select falls on the first clock edge at which `ready_in` is high.
- R6: A no-wait write (`req_kind` = 2'b10, same frame as R1) and a register read both lower chip select on the acceptance edge, whatever the level of `ready_in`.
- R7: SPI mode 0: `sclk` is low whenever no byte is being shifted. Each level lasts H system cycles, and `mosi` changes only while `sclk` is low. Each successive byte starts 16H+1 cycles after the previous one.
- R8: A request with `req_kind` = 2'b11 (stream byte) lowers `dat_csn` only and sends `req_wdata[7:0]` as one byte, with the same guard timing as R4.
- R9: After reset, both chip selects are high, and `sclk`, `busy`, `done` and `rdata` are zero.
- R10: `busy` rises on the acceptance edge and falls on the edge that raises chip select. A request presented while `busy` is high is dropped without effect.
- R11: Every accepted request of any kind ends with `done` high for exactly one cycle, on the same edge that releases its chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_kind | input | 2 | 00 read, 01 write, 10 write without ready check, 11 stream byte |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write data; the low byte is the stream byte |
| guard_len | input | GUARD_W | Guard interval in cycles around chip select |
| ready_in | input | 1 | Peripheral ready line, high when it can take a write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last completed read |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI data to the peripheral |
| miso | input | 1 | SPI data from the peripheral |
| ctl_csn | output | 1 | Register-access chip select, active low |
| dat_csn | output | 1 | Stream-data chip select, active low |

## Verification
The bound checker enforces the per-cycle invariants on every cycle. The two chip selects are never low together, and `sclk` stays idle while neither is low. `busy` covers any low chip select. A control chip-select release, or the fall of `busy`, always coincides with a single-cycle `done`, and `rdata` moves only with `done`. The exact byte contents, the guard lengths, the wait on the ready line and the dropping of requests made while busy depend on what was requested. Only the bench's scenarios can show these. Its reference model predicts `sclk`, `mosi`, both chip selects, `busy`, `done` and `rdata` every cycle, and a peripheral model commits writes and answers reads.

// File: rtl/regspi_pkg.sv
package regspi_pkg;

    typedef enum logic [1:0] {
        KIND_READ         = 2'b00,
        KIND_WRITE        = 2'b01,
        KIND_WRITE_NOWAIT = 2'b10,
        KIND_STREAM       = 2'b11
    } req_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_LEAD,
        SQ_XFER,
        SQ_TRAIL
    } seq_state_e;

    localparam logic [7:0] OPC_REG_WRITE = 8'h02;
    localparam logic [7:0] OPC_REG_READ  = 8'h03;
    localparam logic [7:0] FILL_BYTE     = 8'hFF;

    typedef struct packed {
        req_kind_e   kind;
        logic [7:0]  addr;
        logic [15:0] wdata;
    } reg_req_t;

    // Byte sent in slot idx of the frame for request r
    function automatic logic [7:0] frame_byte(reg_req_t r, logic [1:0] idx);
        logic is_rd;
        is_rd = (r.kind == KIND_READ);
        if (r.kind == KIND_STREAM) begin
            return r.wdata[7:0];
        end
        case (idx)
            2'd0:    return is_rd ? OPC_REG_READ : OPC_REG_WRITE;
            2'd1:    return r.addr;
            2'd2:    return is_rd ? FILL_BYTE : r.wdata[15:8];
            default: return is_rd ? FILL_BYTE : r.wdata[7:0];
        endcase
    endfunction

    function automatic logic [1:0] last_slot(req_kind_e k);
        return (k == KIND_STREAM) ? 2'd0 : 2'd3;
    endfunction

    function automatic logic must_wait_ready(req_kind_e k);
        return k == KIND_WRITE;
    endfunction

    function automatic logic on_data_select(req_kind_e k);
        return k == KIND_STREAM;
    endfunction

endpackage

// File: rtl/regspi_byte_engine.sv
module regspi_byte_engine #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic             active;
    logic             sclk_q;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sclk_q  <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !active) begin
                active  <= 1'b1;
                tx_sh   <= tx_byte;
                div_cnt <= '0;
                bit_cnt <= '0;
                sclk_q  <= 1'b0;
            end else if (active) begin
                if (div_cnt == DIV_LAST) begin
                    div_cnt <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_sh  <= {rx_sh[6:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_cnt == 3'd7) begin
                            active <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

    assign sclk      = sclk_q;
    assign mosi      = tx_sh[7];
    assign byte_done = done_q;
    assign rx_byte   = rx_sh;

endmodule

// File: rtl/regspi_guard_timer.sv
module regspi_guard_timer #(
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [GUARD_W-1:0] load_val,
    output logic               expired
);
    logic [GUARD_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/regspi_sequencer.sv
module regspi_sequencer
    import regspi_pkg::*;
#(
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  reg_req_t           req,
    input  logic [GUARD_W-1:0] guard_len,
    input  logic               ready_in,
    input  logic               byte_done,
    input  logic [7:0]         rx_byte,
    input  logic               timer_zero,
    output logic               timer_load,
    output logic [GUARD_W-1:0] timer_val,
    output logic               eng_start,
    output logic [7:0]         eng_tx,
    output logic               ctl_csn,
    output logic               dat_csn,
    output logic               busy,
    output logic               done,
    output logic [15:0]        rdata
);
    seq_state_e         state;
    reg_req_t           cur;
    logic [GUARD_W-1:0] guard_q;
    logic [1:0]         slot;
    logic [7:0]         rx_hi;
    logic [7:0]         rx_lo;

    logic       accept;
    logic       open_now;
    logic       open_late;
    logic       slot_end;
    logic       last;
    logic [1:0] next_slot;

    always_comb begin
        accept     = (state == SQ_IDLE) && req_valid;
        open_now   = accept && !(must_wait_ready(req.kind) && !ready_in);
        open_late  = (state == SQ_WAIT) && ready_in;
        last       = (slot == last_slot(cur.kind));
        slot_end   = (state == SQ_XFER) && byte_done;
        timer_load = open_now || open_late || (slot_end && last);
        timer_val  = (state == SQ_IDLE) ? guard_len : guard_q;
        eng_start  = ((state == SQ_LEAD) && timer_zero) || (slot_end && !last);
        next_slot  = (state == SQ_LEAD) ? 2'd0 : slot + 2'd1;
        eng_tx     = frame_byte(cur, next_slot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            cur     <= '0;
            guard_q <= '0;
            slot    <= '0;
            rx_hi   <= '0;
            rx_lo   <= '0;
            ctl_csn <= 1'b1;
            dat_csn <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        cur     <= req;
                        guard_q <= guard_len;
                        busy    <= 1'b1;
                        if (open_now) begin
                            state <= SQ_LEAD;
                            if (on_data_select(req.kind)) dat_csn <= 1'b0;
                            else                          ctl_csn <= 1'b0;
                        end else begin
                            state <= SQ_WAIT;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (open_late) begin
                        state   <= SQ_LEAD;
                        ctl_csn <= 1'b0;
                    end
                end
                SQ_LEAD: begin
                    if (timer_zero) begin
                        state <= SQ_XFER;
                        slot  <= 2'd0;
                    end
                end
                SQ_XFER: begin
                    if (byte_done) begin
                        if (slot == 2'd2) rx_hi <= rx_byte;
                        if (last) begin
                            rx_lo <= rx_byte;
                            state <= SQ_TRAIL;
                        end else begin
                            slot <= slot + 2'd1;
                        end
                    end
                end
                SQ_TRAIL: begin
                    if (timer_zero) begin
                        state   <= SQ_IDLE;
                        ctl_csn <= 1'b1;
                        dat_csn <= 1'b1;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        if (cur.kind == KIND_READ) rdata <= {rx_hi, rx_lo};
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/regspi_master.sv
module regspi_master
    import regspi_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int GUARD_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [7:0]         req_addr,
    input  logic [15:0]        req_wdata,
    input  logic [GUARD_W-1:0] guard_len,
    input  logic               ready_in,
    output logic               busy,
    output logic               done,
    output logic [15:0]        rdata,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic               ctl_csn,
    output logic               dat_csn
);
    reg_req_t           req_s;
    logic               timer_load;
    logic [GUARD_W-1:0] timer_val;
    logic               timer_zero;
    logic               eng_start;
    logic [7:0]         eng_tx;
    logic               byte_done;
    logic [7:0]         rx_byte;

    always_comb begin
        req_s.kind  = req_kind_e'(req_kind);
        req_s.addr  = req_addr;
        req_s.wdata = req_wdata;
    end

    regspi_sequencer #(.GUARD_W(GUARD_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req        (req_s),
        .guard_len  (guard_len),
        .ready_in   (ready_in),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .timer_zero (timer_zero),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .eng_start  (eng_start),
        .eng_tx     (eng_tx),
        .ctl_csn    (ctl_csn),
        .dat_csn    (dat_csn),
        .busy       (busy),
        .done       (done),
        .rdata      (rdata)
    );

    regspi_guard_timer #(.GUARD_W(GUARD_W)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_zero)
    );

    regspi_byte_engine #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (eng_start),
        .tx_byte   (eng_tx),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

endmodule

// File: rtl/regspi_checker.sv
module regspi_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [15:0] rdata,
    input logic        sclk,
    input logic        ctl_csn,
    input logic        dat_csn
);
    // R3: the two selects are never active together
    a_r3_cs_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!ctl_csn && !dat_csn));

    // R7: clock idles low whenever no select is active
    a_r7_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        (ctl_csn && dat_csn) |-> !sclk);

    // R10: an active select is always covered by busy
    a_r10_cs_under_busy: assert property (@(posedge clk) disable iff (rst)
        (!ctl_csn || !dat_csn) |-> busy);

    // R11: done lasts a single cycle
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10, R11: busy ends together with the done pulse
    a_r11_busy_fall_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R3: control select is released only at completion
    a_r3_release_done: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_csn) |-> done);

    // R2: read result moves only with done
    a_r2_rdata_at_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> done);
endmodule

bind regspi_master regspi_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .rdata   (rdata),
    .sclk    (sclk),
    .ctl_csn (ctl_csn),
    .dat_csn (dat_csn)
);

// File: tb/regspi_master_test.sv
`timescale 1ns/1ps
module regspi_master_test;
    localparam int H  = 2;
    localparam int GW = 8;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic [7:0]    req_addr = 8'h00;
    logic [15:0]   req_wdata = 16'h0000;
    logic [GW-1:0] guard_len = '0;
    logic          ready_in = 1'b1;
    logic          busy, done, sclk, mosi, miso, ctl_csn, dat_csn;
    logic [15:0]   rdata;

    always #2 clk = ~clk;

    regspi_master #(.HALF_DIV(H), .GUARD_W(GW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .guard_len(guard_len),
        .ready_in(ready_in), .busy(busy), .done(done), .rdata(rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ctl_csn(ctl_csn), .dat_csn(dat_csn)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] seed_word(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {b, ~b} ^ 16'h3C5A;
    endfunction

    // ---------------- peripheral model ----------------
    int          p_bits = 0;
    logic [31:0] p_in = '0;
    logic [15:0] p_resp = '0;
    logic [15:0] p_mem [256];
    logic [7:0]  stream_exp = '0;

    initial begin
        for (int i = 0; i < 256; i++) p_mem[i] = seed_word(i);
    end

    always @(negedge ctl_csn or negedge dat_csn) p_bits = 0;

    always @(posedge sclk) begin
        p_in = {p_in[30:0], mosi};
        p_bits++;
        if (p_bits == 16) p_resp = p_mem[p_in[7:0]];
    end

    assign miso = (p_bits >= 16 && p_bits < 32) ? p_resp[31 - p_bits] : 1'b0;

    always @(posedge ctl_csn) begin
        if (!rst) begin
            chk("R3 control frame bit count", 32'(p_bits), 32'd32);
            if (p_bits == 32 && p_in[31:24] == 8'h02) p_mem[p_in[23:16]] = p_in[15:0];
        end
    end

    always @(posedge dat_csn) begin
        if (!rst) begin
            chk("R8 stream bit count", 32'(p_bits), 32'd8);
            chk("R8 stream byte", 32'(p_in[7:0]), 32'(stream_exp));
        end
    end

    // ---------------- cycle reference model ----------------
    logic [15:0] exp_mem [256];
    int   m_busy = 0, m_wait = 0, m_t = 0, m_L = 0, m_N = 0, m_G = 0;
    int   m_kind = 0, m_addr = 0;
    logic [15:0] m_wdata = '0;
    logic m_ctl = 1'b1, m_dat = 1'b1, m_done = 1'b0;
    logic [15:0] m_rdata = '0;
    logic [7:0]  mb [4];

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = seed_word(i);
    end

    always @(posedge clk) begin
        m_done = 1'b0;
        if (rst) begin
            m_busy = 0; m_wait = 0; m_t = 0;
            m_ctl = 1'b1; m_dat = 1'b1; m_rdata = '0;
        end else if (m_busy == 0) begin
            if (req_valid) begin
                m_busy = 1;
                m_kind = int'(req_kind);
                m_addr = int'(req_addr);
                m_wdata = req_wdata;
                m_G = int'(guard_len);
                if (m_kind == 3) begin
                    m_N = 1; mb[0] = req_wdata[7:0];
                end else begin
                    m_N = 4;
                    mb[0] = (m_kind == 0) ? 8'h03 : 8'h02;
                    mb[1] = req_addr;
                    mb[2] = (m_kind == 0) ? 8'hFF : req_wdata[15:8];
                    mb[3] = (m_kind == 0) ? 8'hFF : req_wdata[7:0];
                end
                m_L = 2 * m_G + m_N * (16 * H + 1) + 2;
                if (m_kind == 1 && !ready_in) m_wait = 1;
                else begin
                    m_t = 0;
                    if (m_kind == 3) m_dat = 1'b0; else m_ctl = 1'b0;
                end
            end
        end else if (m_wait != 0) begin
            if (ready_in) begin
                m_wait = 0; m_t = 0; m_ctl = 1'b0;
            end
        end else begin
            m_t++;
            if (m_t == m_L) begin
                m_ctl = 1'b1; m_dat = 1'b1; m_busy = 0; m_done = 1'b1;
                if (m_kind == 0) m_rdata = exp_mem[m_addr];
                if (m_kind == 1 || m_kind == 2) exp_mem[m_addr] = m_wdata;
            end
        end
    end

    bit started = 0;

    always @(negedge clk) begin
        if (started) begin
            logic exp_sclk;
            int   b, u;
            logic in_win;
            string dtag;
            exp_sclk = 1'b0; in_win = 1'b0; b = 0; u = 0;
            if ((!m_ctl || !m_dat) && m_t >= m_G + 1) begin
                b = (m_t - m_G - 1) / (16 * H + 1);
                u = (m_t - m_G - 1) % (16 * H + 1);
                if (b < m_N && u < 16 * H) begin
                    in_win = 1'b1;
                    exp_sclk = ((u / H) % 2) == 1;
                end
            end
            dtag = (m_kind == 0) ? "R2 mosi read frame" :
                   (m_kind == 3) ? "R8 mosi stream byte" : "R1 mosi write frame";
            chk("R3/R5 ctl_csn", 32'(ctl_csn), 32'(m_ctl));
            chk("R8 dat_csn", 32'(dat_csn), 32'(m_dat));
            chk("R4/R7 sclk", 32'(sclk), 32'(exp_sclk));
            if (in_win) chk(dtag, 32'(mosi), 32'(mb[b][7 - u / (2 * H)]));
            chk("R10 busy", 32'(busy), 32'(m_busy != 0));
            chk("R11 done", 32'(done), 32'(m_done));
            chk("R2 rdata", 32'(rdata), 32'(m_rdata));
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [1:0] k, input logic [7:0] a,
                         input logic [15:0] d, input logic [GW-1:0] g);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d; guard_len = g;
        if (k == 2'b11) stream_exp = d[7:0];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        started = 1;
        chk("R9 reset ctl_csn", 32'(ctl_csn), 32'd1);
        chk("R9 reset dat_csn", 32'(dat_csn), 32'd1);
        chk("R9 reset sclk", 32'(sclk), 32'd0);
        chk("R9 reset busy", 32'(busy), 32'd0);
        chk("R9 reset rdata", 32'(rdata), 32'd0);
        rst = 1'b0;

        // R1, R4: write with guard 3
        issue(2'b01, 8'h0B, 16'h1234, 8'd3);
        wait_idle();
        // R2: read back, guard 0
        issue(2'b00, 8'h0B, 16'h0000, 8'd0);
        wait_idle();
        chk("R2 read after write", 32'(rdata), 32'h1234);
        // R2: untouched register
        issue(2'b00, 8'h05, 16'h0000, 8'd1);
        wait_idle();
        chk("R2 read seed word", 32'(rdata), 32'(seed_word(5)));
        // R8: stream byte, rdata unchanged
        issue(2'b11, 8'h00, 16'h55A7, 8'd2);
        wait_idle();
        chk("R8 rdata kept after stream", 32'(rdata), 32'(seed_word(5)));

        // R5: write held until ready
        ready_in = 1'b0;
        issue(2'b01, 8'h22, 16'hBEEF, 8'd1);
        repeat (12) @(negedge clk);
        chk("R5 ctl_csn held while not ready", 32'(ctl_csn), 32'd1);
        chk("R5 busy while waiting", 32'(busy), 32'd1);
        ready_in = 1'b1;
        wait_idle();

        // R6: no-wait write and read with ready low
        ready_in = 1'b0;
        issue(2'b10, 8'h23, 16'h0F0F, 8'd4);
        wait_idle();
        issue(2'b00, 8'h23, 16'h0000, 8'd0);
        wait_idle();
        chk("R6 no-wait write then read", 32'(rdata), 32'h0F0F);
        ready_in = 1'b1;

        // R10: request during busy is dropped
        issue(2'b00, 8'h0B, 16'h0000, 8'd2);
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b01; req_addr = 8'h0B; req_wdata = 16'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        issue(2'b00, 8'h0B, 16'h0000, 8'd0);
        wait_idle();
        chk("R10 write during busy ignored", 32'(rdata), 32'h1234);

        // R4: long guard, read back earlier waited write
        issue(2'b00, 8'h22, 16'h0000, 8'd20);
        wait_idle();
        chk("R5 waited write landed", 32'(rdata), 32'hBEEF);

        // R9: reset in the middle of a write
        issue(2'b01, 8'h40, 16'h7777, 8'd0);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 mid reset ctl_csn", 32'(ctl_csn), 32'd1);
        chk("R9 mid reset busy", 32'(busy), 32'd0);
        rst = 1'b0;
        issue(2'b00, 8'h40, 16'h0000, 8'd1);
        wait_idle();
        chk("R9 aborted write not committed", 32'(rdata), 32'(seed_word(64)));

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule